// File: doc/BRIEF.md
# Shared-Bus Wishbone Interconnect with Self-Describing Slave Windows

This block joins several Wishbone masters to several Wishbone slaves over one shared request path. A round-robin arbiter hands the bus to one master at a time. That master's address, write data, byte selects, write flag and cycle/burst tags go out on a common slave request bus. The interconnect then raises cycle and strobe on exactly one slave, and returns that slave's read data and acknowledge to the owning master only.

Address decoding uses no fixed table. Every slave publishes a 64-bit window word: the upper half holds its base address and the lower half holds an address mask. The decoder compares the word address of the master (byte address bits 31..2) against each window in parallel. When two windows overlap, the lower slave index wins. When an address falls outside every window, the interconnect answers with its own acknowledge and zero data, so the master is not left waiting.

Top module: `wb_shared_xbar`

## Requirements
- R1: After reset, and whenever no master holds cycle high, every slave cycle and strobe is low, every master acknowledge is low, and the shared slave request fields (address, data, select, write, cycle-type tag, burst-type tag) are all zero.
- R2: Slave j is a match for word address A (byte address bits 31..2) when ((window bits 63..34 XOR A) AND window bits 31..2) is zero. A transfer to a matching address is acknowledged with that slave's read data.
- R3: When several slaves match, the lowest-numbered matching slave is the one selected.
- R4: When no slave matches, the owning master gets one acknowledge, one cycle after its strobe is seen on the granted bus, with all-zero read data. That acknowledge never lasts two cycles in a row.
- R5: Cycle and strobe reach only the selected slave. At most one slave cycle line is high at a time, and strobe is never high on a slave without its cycle line.
- R6: Only the granted master can see acknowledge high, and only the granted master sees the routed read data. Every other master reads zero data.
- R7: Among masters that request at once, the grant goes round-robin: the search starts at the master after the previous owner.
- R8: The grant stays with the owning master as long as its cycle stays high, even while its strobe is low. Other masters receive nothing in that time.
- R9: The grant is registered. A master first reaches the slaves in the cycle after it raises cycle on an idle bus. While it owns the bus, its address, write data, select, write flag, cycle-type tag and burst-type tag appear unchanged on the shared slave request bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| m_adr_i | input | N_MST*(ADR_W-2) | Word addresses of all masters, master i at slice i |
| m_dat_i | input | N_MST*DAT_W | Write data of all masters |
| m_sel_i | input | N_MST*SEL_W | Byte selects of all masters |
| m_we_i | input | N_MST | Write flags |
| m_stb_i | input | N_MST | Strobes |
| m_cyc_i | input | N_MST | Cycle (bus request) lines |
| m_cti_i | input | N_MST*3 | Cycle-type tags |
| m_bte_i | input | N_MST*2 | Burst-type tags |
| m_dat_o | output | N_MST*DAT_W | Read data returned to each master |
| m_ack_o | output | N_MST | Acknowledge to each master |
| s_adr_o | output | ADR_W-2 | Shared word address to slaves |
| s_dat_o | output | DAT_W | Shared write data |
| s_sel_o | output | SEL_W | Shared byte selects |
| s_we_o | output | 1 | Shared write flag |
| s_cti_o | output | 3 | Shared cycle-type tag |
| s_bte_o | output | 2 | Shared burst-type tag |
| s_cyc_o | output | N_SLV | Per-slave cycle |
| s_stb_o | output | N_SLV | Per-slave strobe |
| s_dat_i | input | N_SLV*DAT_W | Read data of all slaves |
| s_ack_i | input | N_SLV | Acknowledge of all slaves |
| s_cfg_i | input | N_SLV*2*ADR_W | Window words (base high, mask low) of all slaves |

## Verification
Two windows overlap on purpose, so a decoder that picked the highest match would return the wrong slave's data tag. A narrow window sits inside an otherwise unclaimed region, so a design that ignored the mask bits or the XOR ordering would miss it or claim neighbours. Addresses that fall outside every window check that the fallback acknowledge comes once with zero data. A design without the fallback would hang the transfer, and one that kept the fallback acknowledge high would show it twice. A three-way contention right after a known owner checks the rotation order, and an owner that keeps cycle high with strobe low checks that a waiting master is held off until cycle falls.

// File: rtl/wbx_pkg.sv
package wbx_pkg;
  localparam int unsigned CTI_W  = 3;
  localparam int unsigned BTE_W  = 2;
  localparam int unsigned GRAN_W = 8;
  localparam int unsigned ADR_LO = 2;  // byte offset bits carried by select
endpackage

// File: rtl/wbx_rr_arb.sv
module wbx_rr_arb #(
  parameter int unsigned N  = 4,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  output logic          busy_o,
  output logic [IW-1:0] owner_o
);
  logic          busy_q;
  logic [IW-1:0] owner_q;
  logic [IW-1:0] pick;
  logic          found;
  logic          hold;

  // search begins one past the last owner
  always_comb begin
    pick  = owner_q;
    found = 1'b0;
    for (int k = 1; k <= int'(N); k++) begin
      int c;
      c = (int'(owner_q) + k) % int'(N);
      if (!found && req_i[c]) begin
        pick  = IW'(c);
        found = 1'b1;
      end
    end
  end

  assign hold = busy_q && req_i[owner_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      owner_q <= IW'(N-1);
    end else begin
      busy_q <= hold || found;
      if (!hold && found) owner_q <= pick;
    end
  end

  assign busy_o  = busy_q;
  assign owner_o = owner_q;

  p_grant_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && req_i[owner_q]) |=> (busy_q && $stable(owner_q)));
endmodule

// File: rtl/wbx_win_decode.sv
module wbx_win_decode #(
  parameter int unsigned N_SLV = 16,
  parameter int unsigned ADR_W = 32,
  localparam int unsigned BA_W  = ADR_W - wbx_pkg::ADR_LO,
  localparam int unsigned CFG_W = 2 * ADR_W,
  localparam int unsigned SIW   = (N_SLV > 1) ? $clog2(N_SLV) : 1
) (
  input  logic [BA_W-1:0]        adr_i,
  input  logic [N_SLV*CFG_W-1:0] cfg_i,
  output logic                   hit_o,
  output logic [SIW-1:0]         idx_o
);
  logic [N_SLV-1:0] match;

  for (genvar g = 0; g < N_SLV; g++) begin : g_win
    logic [BA_W-1:0] base, mask;
    assign base = cfg_i[g*CFG_W + CFG_W - 1 -: BA_W];
    assign mask = cfg_i[g*CFG_W + ADR_W - 1 -: BA_W];
    assign match[g] = ((base ^ adr_i) & mask) == '0;
  end

  // lowest index wins
  always_comb begin
    idx_o = '0;
    for (int k = int'(N_SLV) - 1; k >= 0; k--)
      if (match[k]) idx_o = SIW'(k);
  end

  assign hit_o = |match;
endmodule

// File: rtl/wb_shared_xbar.sv
module wb_shared_xbar #(
  parameter int unsigned N_MST = 4,
  parameter int unsigned N_SLV = 16,
  parameter int unsigned DAT_W = 32,
  parameter int unsigned ADR_W = 32,
  localparam int unsigned SEL_W = DAT_W / wbx_pkg::GRAN_W,
  localparam int unsigned BA_W  = ADR_W - wbx_pkg::ADR_LO,
  localparam int unsigned CFG_W = 2 * ADR_W,
  localparam int unsigned CTI_W = wbx_pkg::CTI_W,
  localparam int unsigned BTE_W = wbx_pkg::BTE_W,
  localparam int unsigned MIW   = (N_MST > 1) ? $clog2(N_MST) : 1,
  localparam int unsigned SIW   = (N_SLV > 1) ? $clog2(N_SLV) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_MST*BA_W-1:0]  m_adr_i,
  input  logic [N_MST*DAT_W-1:0] m_dat_i,
  input  logic [N_MST*SEL_W-1:0] m_sel_i,
  input  logic [N_MST-1:0]       m_we_i,
  input  logic [N_MST-1:0]       m_stb_i,
  input  logic [N_MST-1:0]       m_cyc_i,
  input  logic [N_MST*CTI_W-1:0] m_cti_i,
  input  logic [N_MST*BTE_W-1:0] m_bte_i,
  output logic [N_MST*DAT_W-1:0] m_dat_o,
  output logic [N_MST-1:0]       m_ack_o,
  output logic [BA_W-1:0]        s_adr_o,
  output logic [DAT_W-1:0]       s_dat_o,
  output logic [SEL_W-1:0]       s_sel_o,
  output logic                   s_we_o,
  output logic [CTI_W-1:0]       s_cti_o,
  output logic [BTE_W-1:0]       s_bte_o,
  output logic [N_SLV-1:0]       s_cyc_o,
  output logic [N_SLV-1:0]       s_stb_o,
  input  logic [N_SLV*DAT_W-1:0] s_dat_i,
  input  logic [N_SLV-1:0]       s_ack_i,
  input  logic [N_SLV*CFG_W-1:0] s_cfg_i
);
  logic           busy;
  logic [MIW-1:0] own;
  logic           active;
  logic           g_stb;
  logic [BA_W-1:0] g_adr;
  logic           hit;
  logic [SIW-1:0] sidx;
  logic           miss_ack_q;
  logic           resp_ack;
  logic [DAT_W-1:0] resp_dat;

  wbx_rr_arb #(.N(N_MST)) u_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (m_cyc_i),
    .busy_o (busy),
    .owner_o(own)
  );

  assign active = busy && m_cyc_i[own];
  assign g_stb  = m_stb_i[own];
  assign g_adr  = m_adr_i[own*BA_W +: BA_W];

  wbx_win_decode #(.N_SLV(N_SLV), .ADR_W(ADR_W)) u_dec (
    .adr_i(g_adr),
    .cfg_i(s_cfg_i),
    .hit_o(hit),
    .idx_o(sidx)
  );

  // shared request path: idle values when nobody owns the bus
  always_comb begin
    if (active) begin
      s_adr_o = g_adr;
      s_dat_o = m_dat_i[own*DAT_W +: DAT_W];
      s_sel_o = m_sel_i[own*SEL_W +: SEL_W];
      s_we_o  = m_we_i[own];
      s_cti_o = m_cti_i[own*CTI_W +: CTI_W];
      s_bte_o = m_bte_i[own*BTE_W +: BTE_W];
    end else begin
      s_adr_o = '0;
      s_dat_o = '0;
      s_sel_o = '0;
      s_we_o  = 1'b0;
      s_cti_o = '0;
      s_bte_o = '0;
    end
  end

  for (genvar j = 0; j < N_SLV; j++) begin : g_slv
    logic sel_here;
    assign sel_here   = active && hit && (sidx == SIW'(j));
    assign s_cyc_o[j] = sel_here;
    assign s_stb_o[j] = sel_here && g_stb;
  end

  // fallback responder for unclaimed addresses
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) miss_ack_q <= 1'b0;
    else         miss_ack_q <= active && g_stb && !hit && !miss_ack_q;
  end

  assign resp_ack = hit ? s_ack_i[sidx] : miss_ack_q;
  assign resp_dat = hit ? s_dat_i[sidx*DAT_W +: DAT_W] : '0;

  for (genvar i = 0; i < N_MST; i++) begin : g_mst
    logic own_here;
    assign own_here = active && (own == MIW'(i));
    assign m_ack_o[i] = own_here && g_stb && resp_ack;
    assign m_dat_o[i*DAT_W +: DAT_W] = own_here ? resp_dat : '0;
  end

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_cyc_i == '0) |-> (s_cyc_o == '0 && m_ack_o == '0 && s_adr_o == '0));
  p_miss_once_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_ack_q |=> !miss_ack_q);
  p_single_slave_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(s_cyc_o) && ((s_stb_o & ~s_cyc_o) == '0));
  p_single_ack_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(m_ack_o));
  p_ack_to_owner_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_ack_o != '0) |-> busy);
endmodule

// File: tb/wb_shared_xbar_bench.sv
module wb_shared_xbar_bench;
  localparam int NM = 4;
  localparam int NS = 16;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk_i = ~clk_i;

  logic [NM*30-1:0] m_adr_i;
  logic [NM*32-1:0] m_dat_i;
  logic [NM*4-1:0]  m_sel_i;
  logic [NM-1:0]    m_we_i, m_stb_i, m_cyc_i;
  logic [NM*3-1:0]  m_cti_i;
  logic [NM*2-1:0]  m_bte_i;
  logic [NM*32-1:0] m_dat_o;
  logic [NM-1:0]    m_ack_o;
  logic [29:0]      s_adr_o;
  logic [31:0]      s_dat_o;
  logic [3:0]       s_sel_o;
  logic             s_we_o;
  logic [2:0]       s_cti_o;
  logic [1:0]       s_bte_o;
  logic [NS-1:0]    s_cyc_o, s_stb_o, s_ack_i;
  logic [NS*32-1:0] s_dat_i;
  logic [NS*64-1:0] s_cfg_i;

  logic [29:0] ma [NM];
  logic [31:0] md [NM];
  logic [3:0]  msel [NM];
  logic [2:0]  mcti [NM];
  logic [1:0]  mbte [NM];
  logic        mwe [NM], mstb [NM], mcyc [NM];

  int total = 0;
  int bad = 0;

  wb_shared_xbar u_wb_shared_xbar (
    .clk_i, .rst_ni, .m_adr_i, .m_dat_i, .m_sel_i, .m_we_i, .m_stb_i, .m_cyc_i,
    .m_cti_i, .m_bte_i, .m_dat_o, .m_ack_o, .s_adr_o, .s_dat_o, .s_sel_o,
    .s_we_o, .s_cti_o, .s_bte_o, .s_cyc_o, .s_stb_o, .s_dat_i, .s_ack_i, .s_cfg_i
  );

  function automatic logic [63:0] cfg_of(int j);
    if (j < 12)  return {j[3:0], 28'h0, 32'hF000_0000};
    if (j == 12) return {32'h2000_0000, 32'hFFFF_0000};
    if (j == 13) return {32'hE123_4000, 32'hFFFF_F000};
    return {64{1'b1}};
  endfunction

  function automatic int exp_slave(logic [29:0] a);
    for (int j = 0; j < NS; j++) begin
      logic [63:0] c;
      c = cfg_of(j);
      if (((c[63:34] ^ a) & c[31:2]) == 30'h0) return j;
    end
    return -1;
  endfunction

  function automatic logic [31:0] slv_data(int j, logic [29:0] a);
    return {j[3:0], 4'hA, a[23:0]};
  endfunction

  always_comb begin
    for (int j = 0; j < NS; j++) begin
      s_cfg_i[j*64 +: 64] = cfg_of(j);
      s_ack_i[j] = s_stb_o[j];
      s_dat_i[j*32 +: 32] = slv_data(j, s_adr_o);
    end
    for (int i = 0; i < NM; i++) begin
      m_adr_i[i*30 +: 30] = ma[i];
      m_dat_i[i*32 +: 32] = md[i];
      m_sel_i[i*4 +: 4]   = msel[i];
      m_cti_i[i*3 +: 3]   = mcti[i];
      m_bte_i[i*2 +: 2]   = mbte[i];
      m_we_i[i]  = mwe[i];
      m_stb_i[i] = mstb[i];
      m_cyc_i[i] = mcyc[i];
    end
  end

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic clr_mst(int m);
    ma[m] = '0; md[m] = '0; msel[m] = '0; mcti[m] = '0; mbte[m] = '0;
    mwe[m] = 1'b0; mstb[m] = 1'b0; mcyc[m] = 1'b0;
  endtask

  task automatic xfer(int m, logic [31:0] byte_adr, logic [31:0] d, bit we,
                      logic [3:0] sel, logic [2:0] cti, logic [1:0] bte);
    int es;
    int n;
    logic [29:0] a;
    logic [31:0] ed;
    logic [NS-1:0] ecyc;
    a  = byte_adr[31:2];
    es = exp_slave(a);
    ed = (es < 0) ? 32'h0 : slv_data(es, a);
    ecyc = (es < 0) ? '0 : (NS'(1) << es);
    @(negedge clk_i);
    ma[m] = a; md[m] = d; mwe[m] = we; msel[m] = sel; mcti[m] = cti; mbte[m] = bte;
    mcyc[m] = 1'b1; mstb[m] = 1'b1;
    @(negedge clk_i);
    n = 0;
    while (!m_ack_o[m] && n < 20) begin
      @(negedge clk_i);
      n++;
    end
    chk(m_ack_o[m], (es < 0) ? "R4" : "R2", "ack arrives", 64'(m_ack_o), 64'(NM'(1) << m));
    chk(m_dat_o[m*32 +: 32] == ed, (es < 0) ? "R4" : "R3", "read data",
        64'(m_dat_o[m*32 +: 32]), 64'(ed));
    chk(s_cyc_o == ecyc, "R5", "slave cycle lines", 64'(s_cyc_o), 64'(ecyc));
    chk(m_ack_o == (NM'(1) << m), "R6", "only owner acked", 64'(m_ack_o), 64'(NM'(1) << m));
    chk({s_adr_o, s_dat_o, s_sel_o, s_we_o, s_cti_o, s_bte_o} == {a, d, sel, we, cti, bte},
        "R9", "forwarded request", 64'({s_adr_o, s_sel_o, s_we_o, s_cti_o, s_bte_o}),
        64'({a, sel, we, cti, bte}));
    for (int o = 0; o < NM; o++)
      if (o != m) chk(m_dat_o[o*32 +: 32] == 32'h0, "R6", "non-owner data",
                      64'(m_dat_o[o*32 +: 32]), 64'h0);
    clr_mst(m);
    @(negedge clk_i);
    chk(m_ack_o == '0 && s_cyc_o == '0, "R1", "quiet after release",
        64'({m_ack_o, s_cyc_o}), 64'h0);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int order [3];
    int cnt;
    int n;
    int es;
    logic [31:0] r;
    for (int i = 0; i < NM; i++) clr_mst(i);
    void'($urandom(32'd20240));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(m_ack_o == '0 && s_cyc_o == '0 && s_stb_o == '0, "R1", "reset acks/cyc",
        64'({m_ack_o, s_cyc_o}), 64'h0);
    chk({s_adr_o, s_dat_o, s_sel_o, s_we_o, s_cti_o, s_bte_o} == '0, "R1",
        "reset request fields", 64'({s_adr_o, s_cti_o, s_bte_o}), 64'h0);

    // R9: registered grant, no slave reach in the first cycle
    @(negedge clk_i);
    ma[0] = 30'h1400_0004; mcyc[0] = 1'b1; mstb[0] = 1'b1;
    #1;
    chk(s_cyc_o == '0 && m_ack_o == '0, "R9", "no reach before grant",
        64'({s_cyc_o, m_ack_o}), 64'h0);
    @(negedge clk_i);
    chk(s_cyc_o == NS'(1) << 5, "R9", "reach after grant", 64'(s_cyc_o), 64'(NS'(1) << 5));
    clr_mst(0);
    @(negedge clk_i);

    xfer(0, 32'h5000_0010, 32'hDEAD_BEEF, 1'b1, 4'hF, 3'b000, 2'b00);  // R2
    xfer(1, 32'h2000_0100, 32'h1234_5678, 1'b0, 4'h3, 3'b010, 2'b01);  // R3 overlap
    xfer(2, 32'h2100_0000, 32'h0, 1'b0, 4'h8, 3'b111, 2'b10);         // R2
    xfer(3, 32'hE123_4ABC, 32'hCAFE_0001, 1'b1, 4'hC, 3'b001, 2'b11);  // R2 narrow
    xfer(0, 32'hC000_0000, 32'h0, 1'b0, 4'hF, 3'b000, 2'b00);         // R4 miss
    xfer(2, 32'hE000_0008, 32'h5, 1'b1, 4'h1, 3'b000, 2'b00);         // R4 miss

    // R7: after master 1 owns, contention among 0,2,3 -> 2,3,0
    xfer(1, 32'h1000_0000, 32'h0, 1'b0, 4'hF, 3'b000, 2'b00);
    @(negedge clk_i);
    for (int k = 0; k < 3; k++) begin
      int m;
      m = (k == 0) ? 0 : k + 1;
      ma[m] = 30'(m) << 26; mcyc[m] = 1'b1; mstb[m] = 1'b1;
    end
    cnt = 0;
    n = 0;
    while (cnt < 3 && n < 40) begin
      @(negedge clk_i);
      n++;
      for (int m = 0; m < NM; m++)
        if (m_ack_o[m] && cnt < 3) begin
          order[cnt] = m;
          cnt++;
          clr_mst(m);
        end
    end
    chk(cnt == 3, "R7", "all contenders served", 64'(cnt), 64'd3);
    chk(order[0] == 2 && order[1] == 3 && order[2] == 0, "R7", "rotation order",
        64'({order[0][7:0], order[1][7:0], order[2][7:0]}), 64'h020300);
    @(negedge clk_i);

    // R8: owner holds cycle with strobe low; waiter kept off
    ma[0] = 30'h0C00_0000; mcyc[0] = 1'b1; mstb[0] = 1'b1;
    n = 0;
    while (!m_ack_o[0] && n < 20) begin
      @(negedge clk_i);
      n++;
    end
    mstb[0] = 1'b0;
    ma[1] = 30'h1800_0000; mcyc[1] = 1'b1; mstb[1] = 1'b1;
    repeat (5) @(negedge clk_i);
    chk(m_ack_o == '0, "R8", "waiter not acked", 64'(m_ack_o), 64'h0);
    chk(s_cyc_o == NS'(1) << 3 && s_stb_o == '0, "R8", "owner still on bus",
        64'({s_cyc_o, s_stb_o}), 64'(NS'(1) << 19));
    clr_mst(0);
    n = 0;
    while (!m_ack_o[1] && n < 20) begin
      @(negedge clk_i);
      n++;
    end
    chk(m_ack_o[1] && m_dat_o[63:32] == slv_data(6, 30'h1800_0000), "R8",
        "waiter served after release", 64'(m_dat_o[63:32]), 64'(slv_data(6, 30'h1800_0000)));
    clr_mst(1);
    @(negedge clk_i);

    // R4: fallback ack is a single pulse even if strobe stays high
    ma[3] = 30'h3400_0000; mcyc[3] = 1'b1; mstb[3] = 1'b1;
    n = 0;
    while (!m_ack_o[3] && n < 20) begin
      @(negedge clk_i);
      n++;
    end
    @(negedge clk_i);
    chk(m_ack_o[3] == 1'b0, "R4", "fallback ack not doubled", 64'(m_ack_o), 64'h0);
    clr_mst(3);
    @(negedge clk_i);

    for (int it = 0; it < 300; it++) begin
      r = $urandom;
      if (r[31:28] == 4'hF) r[31:28] = 4'h7;
      if ($urandom % 4 == 0) r = 32'hE123_4000 | (r & 32'h0000_0FFF);
      es = exp_slave(r[31:2]);
      xfer(int'($urandom % NM), r, $urandom, 1'($urandom), 4'($urandom),
           3'($urandom), 2'($urandom));
    end

    finish_run();
  end
endmodule